// File: doc/BRIEF.md
# Bus Protocol Violation Monitor

This block sits on the write path between a reconfigurable accelerator region, which is not trusted, and the fixed interconnect of the chip. It observes the write-address, write-data and write-response handshakes of the region's single master port and checks them against AXI4-style channel rules: payloads must hold while a transfer is stalled, the requested transfer size must fit the data bus, the number of requests awaiting a response is bounded, and every accepted request must see a response within a programmable number of cycles.

On the first broken rule the monitor records which checks failed, one bit per check, stamps the cycle in which that happened, raises a level interrupt to the local processor and drives an isolate output that a decoupler uses to cut the region off. From then on the monitor stops checking and holds its record. Only a clear pulse from supervisor software releases isolation, drops the interrupt and restarts checking from a clean state.

Top module: `bus_guard`

## Requirements
- R1: While the write-address valid is high and ready is low in one cycle, the next cycle must show valid still high with the same address, length and size; otherwise error bit 0 is set.
- R2: While the write-data valid is high and ready is low in one cycle, the next cycle must show valid still high with the same data, strobes and last flag; otherwise error bit 1 is set.
- R3: A cycle with the write-address valid high and a size code above log2(DATA_W/8) (2 for a 32-bit bus) sets error bit 2.
- R4: With a nonzero limit L and at least one response outstanding, a response handshake must occur within the L cycles after the most recent request acceptance (each acceptance restarts the wait; the timer stops when nothing is outstanding); otherwise error bit 3 is set at the edge that closes the first cycle past that window. A limit of 0 disables this check.
- R5: Accepting a request while MAX_OUT (default 8) responses are already outstanding, with no response in the same cycle, sets error bit 4.
- R6: At the clock edge that closes a cycle with any violation, every bit detected in that cycle is recorded and isolate and irq go high; both, the error bits and the timestamp then hold until a clear.
- R7: The captured timestamp equals the number of clock edges since reset was released, counted up to the start of the violating cycle.
- R8: While isolated no further check records anything; a clear pulse returns error bits, timestamp, isolate and irq to zero and empties the outstanding count and timer at the next edge.
- R9: After reset, the error bits, timestamp, isolate and irq are all zero.
- R10: Legal traffic (stalls with held payloads, legal sizes, responses within the window) never sets an error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Write-address valid from the region |
| aw_ready | input | 1 | Write-address ready from the interconnect |
| aw_addr | input | ADDR_W | Write address |
| aw_len | input | LEN_W | Burst length |
| aw_size | input | 3 | Transfer size code (bytes = 2^code) |
| w_valid | input | 1 | Write-data valid |
| w_ready | input | 1 | Write-data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last beat of burst |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| tmo_limit | input | TMO_W | Response window in cycles, 0 disables |
| clr_err | input | 1 | Supervisor clear pulse |
| err_flags | output | 5 | One bit per check: 0 address hold, 1 data hold, 2 size, 3 timeout, 4 overflow |
| first_stamp | output | TS_W | Cycle stamp of the violating cycle |
| isolate | output | 1 | Decouple enable for the region |
| irq | output | 1 | Interrupt to the local processor |

## Verification
The hold checks are driven with stalls whose payloads stay put, change, or whose valid drops, which separates a legal stall from each kind of breach and shows two checks firing in one cycle. The response window is tried with a reply just inside it, no reply, a second request that must restart the wait, and a zero limit, which tells an off-by-one window and a missing restart apart from a correct timer. Bursts of back-to-back acceptances reach the outstanding bound exactly and one past it, and stimulus applied while isolated, followed by a clear, shows that isolation freezes the record and that the clear leaves no stale count behind.

// File: rtl/bg_pkg.sv
// Shared constants for the bus protocol violation monitor.
// Assumes: error bit positions below are visible to software.
package bg_pkg;
    localparam int NUM_CHK      = 5;
    localparam int CHK_AW_HOLD  = 0;
    localparam int CHK_W_HOLD   = 1;
    localparam int CHK_SIZE     = 2;
    localparam int CHK_TIMEOUT  = 3;
    localparam int CHK_OVERFLOW = 4;
    typedef logic [NUM_CHK-1:0] chk_vec_t;
endpackage

// File: rtl/bg_stable_chk.sv
// Channel hold checker: flags a payload change or a valid drop in the
// cycle after a stalled transfer (valid high, ready low).
// Assumes: en low means checking is suspended; the stall memory is dropped.
module bg_stable_chk #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         valid,
    input  logic         ready,
    input  logic [W-1:0] payload,
    output logic         viol
);
    logic         stall_q;
    logic [W-1:0] pay_q;

    // Remember whether the last cycle stalled and what it offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            pay_q   <= '0;
        end else begin
            stall_q <= en & valid & ~ready;
            pay_q   <= payload;
        end
    end

    // A stalled transfer must come back unchanged.
    always_comb viol = en & stall_q & (~valid | (payload != pay_q));

    // R1 / R2: a violation is only possible right after a stall.
    p_viol_after_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(en && valid && !ready));
endmodule

// File: rtl/bg_resp_timer.sv
// Outstanding-response tracker with a response window timer.
// Counts accepted requests minus responses, restarts the timer on each
// acceptance, stops it when nothing is outstanding.
// Assumes: limit of zero disables the window check.
module bg_resp_timer #(
    parameter int MAX_OUT = 8,
    parameter int TMO_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             req_acc,
    input  logic             rsp_acc,
    input  logic [TMO_W-1:0] limit,
    output logic             viol_tmo,
    output logic             viol_ovf
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);
    localparam logic [CNT_W-1:0] OUT_MAX = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] out_q, out_d;
    logic [TMO_W-1:0] tmo_q, tmo_d;

    // Next outstanding count, saturating at both ends.
    always_comb begin
        out_d = out_q;
        if (req_acc && !rsp_acc && out_q != OUT_MAX)
            out_d = out_q + 1'b1;
        else if (!req_acc && rsp_acc && out_q != '0)
            out_d = out_q - 1'b1;
    end

    // Next timer value: restart on acceptance, idle at zero when drained.
    always_comb begin
        if (req_acc || out_d == '0)
            tmo_d = '0;
        else if (tmo_q != '1)
            tmo_d = tmo_q + 1'b1;
        else
            tmo_d = tmo_q;
    end

    // Violation outputs.
    always_comb begin
        viol_ovf = en & req_acc & ~rsp_acc & (out_q == OUT_MAX);
        viol_tmo = en & (limit != '0) & (out_q != '0) & (tmo_q >= limit);
    end

    // Counter state, frozen while disabled, emptied by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            out_q <= '0;
            tmo_q <= '0;
        end else if (en) begin
            out_q <= out_d;
            tmo_q <= tmo_d;
        end
    end

    // R5: the count never exceeds its bound.
    p_out_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_q <= OUT_MAX);
    // R4: the timer rests at zero whenever nothing is outstanding.
    p_timer_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q == '0) |-> (tmo_q == '0));
endmodule

// File: rtl/bg_err_capture.sv
// Error capture and isolation control. Records the violation bits of the
// first violating cycle with a cycle stamp, raises isolate and irq and
// holds all of them until clear.
// Assumes: clear has priority over a new capture.
module bg_err_capture #(
    parameter int NUM  = 5,
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [NUM-1:0]  viol,
    output logic [NUM-1:0]  flags,
    output logic [TS_W-1:0] first_ts,
    output logic            isolate,
    output logic            irq
);
    logic [TS_W-1:0] ts_q;
    logic [NUM-1:0]  flags_q;
    logic [TS_W-1:0] first_q;
    logic            iso_q;
    logic            irq_q;

    // Free-running cycle stamp since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    // Capture the first violation and enter isolation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags_q <= '0;
            first_q <= '0;
            iso_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (!iso_q && viol != '0) begin
            flags_q <= viol;
            first_q <= ts_q;
            iso_q   <= 1'b1;
            irq_q   <= 1'b1;
        end
    end

    always_comb begin
        flags    = flags_q;
        first_ts = first_q;
        isolate  = iso_q;
        irq      = irq_q;
    end

    // R6: any violation while active raises isolate and irq.
    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_q && !clear && viol != '0) |=> (iso_q && irq_q));
    // R6: the record holds until clear.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_q && !clear) |=> (iso_q && irq_q && $stable(flags_q) && $stable(first_q)));
    // R8: clear empties the record.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!iso_q && !irq_q && flags_q == '0 && first_q == '0));
endmodule

// File: rtl/bus_guard.sv
// Bus protocol violation monitor for one write master port of an untrusted
// region. Checks payload hold on the address and data channels, legal size,
// outstanding bound and response window; isolates on the first violation.
// Assumes: all inputs synchronous to clk; clr_err is a supervisor pulse.
module bus_guard
    import bg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int MAX_OUT = 8,
    parameter int TMO_W   = 16,
    parameter int TS_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                aw_valid,
    input  logic                aw_ready,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic [LEN_W-1:0]    aw_len,
    input  logic [2:0]          aw_size,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic                b_valid,
    input  logic                b_ready,
    input  logic [TMO_W-1:0]    tmo_limit,
    input  logic                clr_err,
    output logic [NUM_CHK-1:0]  err_flags,
    output logic [TS_W-1:0]     first_stamp,
    output logic                isolate,
    output logic                irq
);
    localparam int STRB_W = DATA_W / 8;
    localparam logic [2:0] SIZE_MAX = 3'($clog2(STRB_W));
    localparam int AW_PW = ADDR_W + LEN_W + 3;
    localparam int W_PW  = DATA_W + STRB_W + 1;

    logic     active;
    chk_vec_t viol_vec;

    // Checking runs only while the region is connected.
    always_comb active = ~isolate;

    bg_stable_chk #(.W(AW_PW)) i_aw_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (active),
        .valid   (aw_valid),
        .ready   (aw_ready),
        .payload ({aw_addr, aw_len, aw_size}),
        .viol    (viol_vec[CHK_AW_HOLD])
    );

    bg_stable_chk #(.W(W_PW)) i_w_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (active),
        .valid   (w_valid),
        .ready   (w_ready),
        .payload ({w_data, w_strb, w_last}),
        .viol    (viol_vec[CHK_W_HOLD])
    );

    // Size code must not exceed the bus width.
    always_comb viol_vec[CHK_SIZE] = active & aw_valid & (aw_size > SIZE_MAX);

    bg_resp_timer #(.MAX_OUT(MAX_OUT), .TMO_W(TMO_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .clear    (clr_err),
        .req_acc  (aw_valid & aw_ready),
        .rsp_acc  (b_valid & b_ready),
        .limit    (tmo_limit),
        .viol_tmo (viol_vec[CHK_TIMEOUT]),
        .viol_ovf (viol_vec[CHK_OVERFLOW])
    );

    bg_err_capture #(.NUM(NUM_CHK), .TS_W(TS_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr_err),
        .viol     (viol_vec),
        .flags    (err_flags),
        .first_ts (first_stamp),
        .isolate  (isolate),
        .irq      (irq)
    );

    // R8: no check reports anything while isolated.
    p_iso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |-> (viol_vec == '0));
    // R3: an oversize request is recorded at the next edge.
    p_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!isolate && !clr_err && aw_valid && aw_size > SIZE_MAX) |=> err_flags[CHK_SIZE]);
endmodule

// File: tb/test_bus_guard.sv
`timescale 1ns/1ps
module test_bus_guard;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        aw_valid, aw_ready;
    logic [31:0] aw_addr;
    logic [7:0]  aw_len;
    logic [2:0]  aw_size;
    logic        w_valid, w_ready;
    logic [31:0] w_data;
    logic [3:0]  w_strb;
    logic        w_last;
    logic        b_valid, b_ready;
    logic [15:0] tmo_limit;
    logic        clr_err;
    logic [4:0]  err_flags;
    logic [15:0] first_stamp;
    logic        isolate, irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] cyc;
    logic [15:0] stamp;

    always #2.5 clk = ~clk;

    // Bench-side cycle count per R7: edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    bus_guard i_bus_guard (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready),
        .tmo_limit(tmo_limit), .clr_err(clr_err),
        .err_flags(err_flags), .first_stamp(first_stamp),
        .isolate(isolate), .irq(irq)
    );

    typedef struct packed {
        logic       clr;
        logic       awv;
        logic       awr;
        logic [7:0] addr;
        logic [2:0] size;
        logic       wv;
        logic       wr;
        logic [7:0] data;
        logic       bv;
        logic       br;
        logic [4:0] exp;
        logic       exp_iso;
    } row_t;

    // One row per cycle; expectations are sampled after that cycle's edge.
    localparam row_t TBL [18] = '{
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h10, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'h10, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h20, 3'd1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h21, 3'd1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00001, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 8'hAA, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 1'b1, 1'b0, 8'hAB, 1'b0, 1'b0, 5'b00010, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'h40, 3'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00100, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h30, 3'd2, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 5'b00000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h30, 3'd2, 1'b1, 1'b0, 8'h12, 1'b0, 1'b0, 5'b00011, 1'b1},
        '{1'b0, 1'b1, 1'b1, 8'h50, 3'd7, 1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 5'b00011, 1'b1},
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'b00000, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        aw_valid = 1'b0; aw_ready = 1'b0; aw_addr = '0; aw_size = 3'd2;
        w_valid = 1'b0; w_ready = 1'b0; w_data = '0;
        b_valid = 1'b0; b_ready = 1'b0; clr_err = 1'b0;
    endtask

    task automatic accept_one();
        aw_valid = 1'b1; aw_ready = 1'b1; aw_size = 3'd2;
        step();
        idle();
    endtask

    task automatic clear_pulse();
        idle();
        clr_err = 1'b1;
        step();
        clr_err = 1'b0;
    endtask

    function automatic string row_tag(input row_t r, input int i);
        if (i == 16)       return "R8 ignored while isolated";
        if (r.clr)         return "R8 clear";
        if (r.exp == 5'b00011) return "R1 R2 same-cycle";
        if (r.exp[0])      return "R1 address hold";
        if (r.exp[1])      return "R2 data hold";
        if (r.exp[2])      return "R3 size";
        return "R10 legal traffic";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        aw_len = '0; w_strb = 4'hF; w_last = 1'b1;
        tmo_limit = 16'd4;
        rst_n = 1'b0;
        repeat (3) step();
        // R9: reset state
        chk(err_flags == 5'b0, "R9 err_flags", err_flags, 0);
        chk(first_stamp == 16'd0, "R9 first_stamp", first_stamp, 0);
        chk(isolate == 1'b0, "R9 isolate", isolate, 0);
        chk(irq == 1'b0, "R9 irq", irq, 0);
        rst_n = 1'b1;
        step();

        // Table walk
        for (int i = 0; i < 18; i++) begin
            clr_err = TBL[i].clr;
            aw_valid = TBL[i].awv; aw_ready = TBL[i].awr;
            aw_addr = {24'h0, TBL[i].addr}; aw_size = TBL[i].size;
            w_valid = TBL[i].wv; w_ready = TBL[i].wr; w_data = {24'h0, TBL[i].data};
            b_valid = TBL[i].bv; b_ready = TBL[i].br;
            step();
            chk(err_flags == TBL[i].exp, row_tag(TBL[i], i), err_flags, TBL[i].exp);
            chk(isolate == TBL[i].exp_iso && irq == TBL[i].exp_iso,
                "R6 isolate/irq level", {isolate, irq}, {2{TBL[i].exp_iso}});
        end
        idle();

        // R4 and R7: timeout with stamp
        tmo_limit = 16'd4;
        accept_one();
        chk(err_flags == 5'b0, "R4 after accept", err_flags, 0);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk(err_flags == 5'b0, "R4 inside window", err_flags, 0);
        end
        stamp = cyc;
        step();
        chk(err_flags == 5'b01000, "R4 timeout bit", err_flags, 5'b01000);
        chk(isolate && irq, "R6 isolate on timeout", {isolate, irq}, 2'b11);
        chk(first_stamp == stamp, "R7 stamp", first_stamp, stamp);
        repeat (3) step();
        chk(first_stamp == stamp && err_flags == 5'b01000 && isolate,
            "R6 record held", first_stamp, stamp);
        clear_pulse();
        chk(!isolate && !irq && err_flags == 5'b0 && first_stamp == 16'd0,
            "R8 clear after timeout", {isolate, irq, err_flags}, 0);

        // R10: response inside the window
        accept_one();
        repeat (3) step();
        b_valid = 1'b1; b_ready = 1'b1;
        step();
        idle();
        repeat (6) step();
        chk(err_flags == 5'b0, "R10 response in time", err_flags, 0);

        // R4: a second acceptance restarts the window
        accept_one();
        repeat (3) step();
        accept_one();
        repeat (3) step();
        chk(err_flags == 5'b0, "R4 restart keeps quiet", err_flags, 0);
        step();
        chk(err_flags == 5'b0, "R4 restart edge", err_flags, 0);
        step();
        chk(err_flags == 5'b01000, "R4 timeout after restart", err_flags, 5'b01000);
        clear_pulse();

        // R4: limit zero disables
        tmo_limit = 16'd0;
        accept_one();
        repeat (20) step();
        chk(err_flags == 5'b0, "R4 disabled by zero", err_flags, 0);
        clear_pulse();

        // R5: outstanding bound
        aw_valid = 1'b1; aw_ready = 1'b1;
        repeat (8) step();
        chk(err_flags == 5'b0, "R5 eight outstanding legal", err_flags, 0);
        step();
        idle();
        chk(err_flags == 5'b10000, "R5 overflow bit", err_flags, 5'b10000);
        clear_pulse();

        // R8: clear emptied counters, so no stale timeout appears
        tmo_limit = 16'd4;
        repeat (8) step();
        chk(err_flags == 5'b0 && !isolate, "R8 counters emptied", err_flags, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule